// File: doc/BRIEF.md
# Serial Divisible-by-Five Detector

This block watches a serial bit stream and reports, on every cycle, whether the number built from all bits accepted since reset is a multiple of five. Bits arrive most significant first. Each accepted bit becomes the new least significant bit of the number, so the number doubles and the bit is added. The stream may be any length. No register that holds the bits could be wide enough, so the block keeps only the running remainder modulo five. That remainder sits in a three-bit state register.

The input is a valid/ready stream. The producer drives `bit_data` and raises `bit_valid`. A bit is accepted on a rising clock edge where `bit_valid` and `bit_ready` are both high. The detector never applies back-pressure: `bit_ready` is always high, including during reset. A producer may therefore treat every cycle with `bit_valid` high as a transfer. Cycles with `bit_valid` low are idle, and `bit_data` is ignored in them. The result `div_flag` is a plain status output, computed from the state register. It changes only after the clock edge that accepts a bit.

Top module: `div5_stream_detector`

## Requirements
- R1: After a synchronous reset (`rst` high on a rising edge), the stored remainder is zero and `div_flag` is high before any bit is accepted.
- R2: A bit accepted on a rising edge extends the number as its new least significant bit (new value = 2 × old value + bit). The remainder after that edge equals the new value modulo five.
- R3: After the accepting edge, `div_flag` is high when the value accepted since reset is divisible by five.
- R4: `div_flag` is low whenever that value is not divisible by five.
- R5: In a cycle with `bit_valid` low, the state and `div_flag` do not change, whatever `bit_data` carries.
- R6: `bit_ready` is high in every cycle.
- R7: The result stays correct for streams far longer than any fixed register width (hundreds of bits).
- R8: Zeros accepted right after reset leave the value at zero, so `div_flag` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | A stream bit is offered this cycle |
| bit_ready | output | 1 | Detector accepts a bit; always high |
| bit_data | input | 1 | Serial data bit, most significant first |
| div_flag | output | 1 | High when the accepted value is a multiple of five |

## Verification
The bench sweeps every bit pattern up to ten bits long and checks the flag after every prefix. A carry or remainder fold done wrong would therefore show up as a wrong flag on some short value, such as 5 (101) or 10 (1010). Idle cycles carry random data bits, so a design that loads on `bit_data` without looking at `bit_valid` would drift away from the true remainder. Long runs of leading zeros and a 600-bit stream target a design that keeps a finite shift register or loses its state across long inputs: such a design would report wrong results once the register wrapped. The reset value is checked on its own, because a design that resets to a nonzero code would show the flag low before any data arrives.

// File: rtl/div5_pkg.sv
package div5_pkg;
  localparam int unsigned DIVISOR = 5;
  localparam int unsigned REM_W   = $clog2(DIVISOR);

  typedef logic [REM_W-1:0] rem_t;
  typedef logic [REM_W:0]   dbl_t;

  localparam rem_t REM_ZERO = '0;
  localparam rem_t REM_LAST = rem_t'(DIVISOR - 1);
  localparam dbl_t DIV_DBL  = dbl_t'(DIVISOR);
endpackage

// File: rtl/div5_rem_step.sv
module div5_rem_step
  import div5_pkg::*;
(
  input  rem_t rem_cur,
  input  logic bit_in,
  output rem_t rem_nxt
);
  dbl_t shifted;

  always_comb begin
    shifted = {rem_cur, bit_in};
    if (rem_cur > REM_LAST) begin
      // unreachable code: fall back to the empty-number remainder
      rem_nxt = REM_ZERO;
    end else if (shifted >= DIV_DBL) begin
      // shifted < 2*DIVISOR, so one subtraction folds it back
      rem_nxt = rem_t'(shifted - DIV_DBL);
    end else begin
      rem_nxt = rem_t'(shifted);
    end
  end
endmodule

// File: rtl/div5_rem_reg.sv
module div5_rem_reg
  import div5_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  rem_t d,
  output rem_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= REM_ZERO;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/div5_flag_decode.sv
module div5_flag_decode
  import div5_pkg::*;
(
  input  rem_t rem,
  output logic is_multiple
);
  assign is_multiple = (rem == REM_ZERO);
endmodule

// File: rtl/div5_stream_detector.sv
module div5_stream_detector
  import div5_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_data,
  output logic div_flag
);
  rem_t rem_q;
  rem_t rem_d;
  logic accept;

  // the remainder machine consumes one bit per cycle: no back-pressure
  assign bit_ready = 1'b1;
  assign accept    = bit_valid & bit_ready;

  div5_rem_step u_step (
    .rem_cur (rem_q),
    .bit_in  (bit_data),
    .rem_nxt (rem_d)
  );

  div5_rem_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .d    (rem_d),
    .q    (rem_q)
  );

  div5_flag_decode u_flag (
    .rem         (rem_q),
    .is_multiple (div_flag)
  );
endmodule

// File: rtl/div5_stream_checker.sv
module div5_stream_checker
  import div5_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic bit_ready,
  input logic bit_data,
  input logic div_flag,
  input rem_t rem_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rem_q == REM_ZERO && div_flag)); // R1

  AST_STEP_MOD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bit_valid)) |->
      (int'(rem_q) == ((2 * int'($past(rem_q)) + int'($past(bit_data))) % DIVISOR))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_valid)) |-> ($stable(rem_q) && $stable(div_flag))); // R5

  AST_REM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rem_q <= REM_LAST); // R3

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    bit_ready); // R6
endmodule

bind div5_stream_detector div5_stream_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .bit_data  (bit_data),
  .div_flag  (div_flag),
  .rem_q     (rem_q)
);

// File: tb/tb_div5_stream_detector.sv
module tb_div5_stream_detector;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic div_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  div5_stream_detector dut (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .bit_data  (bit_data),
    .div_flag  (div_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic send(input logic v, input logic b);
    bit_valid = v;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    longint val;
    int m;
    logic b;
    logic prev_flag;

    @(negedge clk);
    do_reset();
    chk(div_flag, 1'b1, "R1 flag after reset");
    chk(bit_ready, 1'b1, "R6 ready after reset");

    // R2/R3/R4: every pattern of length 1..MAX_LEN, checked after each prefix
    for (int len = 1; len <= MAX_LEN; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        do_reset();
        val = 0;
        for (int k = len - 1; k >= 0; k--) begin
          b = pat[k];
          val = 2 * val + longint'(b);
          send(1'b1, b);
          if (val % 5 == 0) chk(div_flag, 1'b1, "R3 divisible prefix (R2 append)");
          else              chk(div_flag, 1'b0, "R4 non-divisible prefix (R2 append)");
        end
      end
    end

    // R5: idle cycles with random data bits change nothing
    do_reset();
    val = 0;
    for (int k = 0; k < 50; k++) begin
      b = 1'($urandom_range(0, 1));
      val = 2 * val + longint'(b);
      send(1'b1, b);
      chk(div_flag, (val % 5 == 0), "R3/R4 gapped stream");
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
        prev_flag = div_flag;
        send(1'b0, 1'($urandom_range(0, 1)));
        chk(div_flag, prev_flag, "R5 idle hold");
      end
    end

    // R5: an idle 1 after value 2 would make 5; the flag must stay low
    do_reset();
    send(1'b1, 1'b1);
    send(1'b1, 1'b0);
    send(1'b0, 1'b1);
    chk(div_flag, 1'b0, "R5 ignored bit_data");
    send(1'b1, 1'b1);
    chk(div_flag, 1'b1, "R3 value 5 after idle");

    // R8: leading zeros keep the flag high
    do_reset();
    for (int k = 0; k < 40; k++) begin
      send(1'b1, 1'b0);
      chk(div_flag, 1'b1, "R8 leading zero");
    end
    send(1'b1, 1'b1);
    chk(div_flag, 1'b0, "R4 value 1 after zeros");
    send(1'b1, 1'b0);
    send(1'b1, 1'b1);
    chk(div_flag, 1'b1, "R8 value 5 after zeros");

    // R7: long stream, remainder tracked arithmetically in the bench
    do_reset();
    m = 0;
    for (int k = 0; k < 600; k++) begin
      b = 1'($urandom_range(0, 1));
      m = (2 * m + int'(b)) % 5;
      send(1'b1, b);
      chk(div_flag, (m == 0), "R7 long stream");
      chk(bit_ready, 1'b1, "R6 ready during stream");
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule